// File: doc/BRIEF.md
# ADC Sample and Convert Sequencer

This block is the digital controller for a sample-and-hold analog-to-digital converter with four sample/hold channels and one shared converter. It runs each capture as two phases. In the tracking phase, the selected sample/hold channels follow their inputs. In the conversion phase, a single converter digitises the held channels one at a time, always starting with channel 0. The converter is driven through a one-cycle start pulse and answers with a one-cycle done pulse.

Software controls the block through one control word. Writing the word updates the configuration and also issues commands. A tracking bit in the word starts sampling, and in manual mode it also ends sampling. With a hardware trigger source, sampling instead ends on an external trigger pulse or when an internal tracking timer expires. An auto-restart option begins a new tracking phase as soon as the last conversion of a group finishes.

A completion flag in the word shows that a group has been fully converted. Hardware sets the flag, and both hardware and software can clear it. The channel-select field sets how many channels take part. The gang bit chooses between freezing all channels at one instant and letting each channel keep tracking until its own conversion begins. A wide-resolution mode disables the gang option.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After synchronous reset the control word reads 0, `sh_sample` is 0 and `conv_start` is 0.
- R2: With the block idle, writing the control word with bit 0 (tracking) set makes bit 0 read 1 from the next cycle. `sh_sample` then equals the selection mask: channel-select field bits [8:7] 00 gives 0001, 01 gives 0011, and 1x gives 1111.
- R3: With trigger field bits [6:4] = 000, tracking lasts until software writes bit 0 = 0. That write produces a one-cycle `conv_start` for channel 0 in the next cycle, and bit 0 reads 0 from then on.
- R4: With trigger field 001, a one-cycle `ext_trig` ends tracking, giving `conv_start` in the next cycle. With any trigger value other than 000 and 001, tracking ends after exactly `SMP_CYCLES` cycles. With any nonzero trigger value, a software write of bit 0 = 0 does not end tracking.
- R5: The selected channels are converted in ascending order from channel 0, with one `conv_start` per channel. Each start after the first follows the `conv_done` of the previous channel.
- R6: The completion flag (bit 1) rises only on the cycle after the `conv_done` of the last selected channel. It is cleared in the same cycle as the `conv_start` that opens a new group.
- R7: A write with bit 1 = 0 clears the completion flag, and a write with bit 1 = 1 never sets it. Clearing the flag does not change the conversion sequence. If a clear arrives in the same cycle as the final `conv_done`, the flag still ends up set.
- R8: With gang bit 3 = 1 and channel-select not 00, every selected `sh_sample` bit drops together when tracking ends. With gang = 0, channel k keeps tracking until its own conversion starts.
- R9: While the wide-resolution bit 9 is 1, the gang bit reads 0 and writing 1 to it has no effect, so the channels behave as with gang = 0.
- R10: With auto-restart bit 2 = 1, the block enters tracking one cycle after the write that sets it while idle. After the final `conv_done`, bit 0 reads 1 in the same cycle that the completion flag rises. With bit 2 = 0, the block goes idle instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 10 | Control word write data |
| reg_rdata | output | 10 | Control word readback: [9] wide, [8:7] chsel, [6:4] trig, [3] gang, [2] auto, [1] done, [0] tracking |
| ext_trig | input | 1 | External end-of-tracking pulse |
| conv_start | output | 1 | One-cycle converter start pulse |
| conv_chan | output | 2 | Channel being converted |
| conv_done | input | 1 | One-cycle converter completion pulse |
| sh_sample | output | 4 | Per-channel track (1) / hold (0) control |

## Verification
The final `conv_done` of a group and a software write that clears the completion flag can arrive in the same cycle. The bench sets this up by watching the converter model. On the negedge where the model's `conv_done` for the last channel is already high, the bench issues the clearing write, so that both events reach the same clock edge. The flag must read 1 afterwards and tracking must read 0, which shows that the hardware set takes priority and that the sequence finished normally.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int REG_W  = 10;
    localparam int NUM_SH = 4;
    localparam int IDX_W  = $clog2(NUM_SH);

    // control word bit positions
    localparam int B_SMP  = 0;
    localparam int B_DONE = 1;
    localparam int B_AUTO = 2;
    localparam int B_GANG = 3;
    localparam int B_TRIG = 4;
    localparam int B_CHS  = 7;
    localparam int B_WIDE = 9;

    localparam logic [2:0] TRIG_SW  = 3'b000;
    localparam logic [2:0] TRIG_EXT = 3'b001;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_CONV   = 2'd2
    } phase_e;

    typedef struct packed {
        logic       wide;
        logic [1:0] chsel;
        logic [2:0] trig;
        logic       gang;
        logic       auto_go;
    } cfg_t;

    function automatic logic [NUM_SH-1:0] sel_mask(input logic [1:0] chsel);
        case (chsel)
            2'b00:   return 4'b0001;
            2'b01:   return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] last_idx(input logic [1:0] chsel);
        case (chsel)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    function automatic cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        cfg_t c;
        c.wide    = w[B_WIDE];
        c.chsel   = w[B_CHS +: 2];
        c.trig    = w[B_TRIG +: 3];
        c.gang    = w[B_GANG] & ~w[B_WIDE];
        c.auto_go = w[B_AUTO];
        return c;
    endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             hw_set,
    input  logic             hw_clr,
    output cfg_t             cfg,
    output logic             done,
    output logic             cmd_set,
    output logic             cmd_clr
);

    cfg_t cfg_q;
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (we)
                cfg_q <= unpack_cfg(wdata);
            if (hw_set)
                done_q <= 1'b1;
            else if (hw_clr)
                done_q <= 1'b0;
            else if (we && !wdata[B_DONE])
                done_q <= 1'b0;
        end
    end

    assign cfg     = cfg_q;
    assign done    = done_q;
    assign cmd_set = we &  wdata[B_SMP];
    assign cmd_clr = we & ~wdata[B_SMP];

    // R9
    wide_gang_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_q.wide |-> !cfg_q.gang);

    // R7
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(hw_set));

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int SMP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic hit
);

    localparam int CNT_W = $clog2(SMP_CYCLES) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SMP_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || hit)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign hit = run && (cnt == LAST);

    // R4
    tmr_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> cnt == '0);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg,
    input  logic             cmd_set,
    input  logic             cmd_clr,
    input  logic             ext_trig,
    input  logic             tmr_hit,
    input  logic             conv_done,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx,
    output logic             conv_start,
    output logic             done_set,
    output logic             done_clr
);

    phase_e           ph_q, ph_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             start_q, start_d;
    logic             end_src;

    always_comb begin
        if (cfg.trig == TRIG_SW)
            end_src = cmd_clr;
        else if (cfg.trig == TRIG_EXT)
            end_src = ext_trig;
        else
            end_src = tmr_hit;
    end

    always_comb begin
        ph_d     = ph_q;
        idx_d    = idx_q;
        start_d  = 1'b0;
        done_set = 1'b0;
        done_clr = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (cmd_set || cfg.auto_go)
                    ph_d = PH_SAMPLE;
            end
            PH_SAMPLE: begin
                if (end_src) begin
                    ph_d     = PH_CONV;
                    idx_d    = '0;
                    start_d  = 1'b1;
                    done_clr = 1'b1;
                end
            end
            PH_CONV: begin
                if (conv_done && !start_q) begin
                    if (idx_q == last_idx(cfg.chsel)) begin
                        done_set = 1'b1;
                        ph_d     = cfg.auto_go ? PH_SAMPLE : PH_IDLE;
                    end else begin
                        idx_d   = idx_q + 1'b1;
                        start_d = 1'b1;
                    end
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            idx_q   <= '0;
            start_q <= 1'b0;
        end else begin
            ph_q    <= ph_d;
            idx_q   <= idx_d;
            start_q <= start_d;
        end
    end

    assign phase      = ph_q;
    assign idx        = idx_q;
    assign conv_start = start_q;

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

    // R3
    start_origin_chk: assert property (@(posedge clk) disable iff (rst)
        start_q |-> $past(ph_q) != PH_IDLE);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SMP_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ext_trig,
    output logic              conv_start,
    output logic [IDX_W-1:0]  conv_chan,
    input  logic              conv_done,
    output logic [NUM_SH-1:0] sh_sample
);

    cfg_t             cfg;
    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic             done, cmd_set, cmd_clr, done_set, done_clr;
    logic             tmr_run, tmr_hit;
    logic             is_samp, is_conv, simult;
    logic [NUM_SH-1:0] sel;

    adc_seq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .wdata   (reg_wdata),
        .hw_set  (done_set),
        .hw_clr  (done_clr),
        .cfg     (cfg),
        .done    (done),
        .cmd_set (cmd_set),
        .cmd_clr (cmd_clr)
    );

    adc_seq_timer #(.SMP_CYCLES(SMP_CYCLES)) u_tmr (
        .clk (clk),
        .rst (rst),
        .run (tmr_run),
        .hit (tmr_hit)
    );

    adc_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .cmd_set    (cmd_set),
        .cmd_clr    (cmd_clr),
        .ext_trig   (ext_trig),
        .tmr_hit    (tmr_hit),
        .conv_done  (conv_done),
        .phase      (phase),
        .idx        (idx),
        .conv_start (conv_start),
        .done_set   (done_set),
        .done_clr   (done_clr)
    );

    assign is_samp = (phase == PH_SAMPLE);
    assign is_conv = (phase == PH_CONV);
    assign tmr_run = is_samp && (cfg.trig != TRIG_SW) && (cfg.trig != TRIG_EXT);
    assign sel     = sel_mask(cfg.chsel);
    assign simult  = cfg.gang && (cfg.chsel != 2'b00);

    for (genvar g = 0; g < NUM_SH; g++) begin : g_sh
        assign sh_sample[g] = sel[g] &
            (is_samp | (is_conv & ~simult & (IDX_W'(g) > idx)));
    end

    assign conv_chan = idx;
    assign reg_rdata = {cfg.wide, cfg.chsel, cfg.trig, cfg.gang,
                        cfg.auto_go, done, is_samp};

    // R8
    sh_in_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (sh_sample & ~sel) == '0);

    // R6
    done_after_cvt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(conv_done));

    // R6
    done_clr_at_open_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_start && conv_chan == '0) |-> !done);

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

    localparam int SMP = 8;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [9:0] reg_wdata = '0;
    logic [9:0] reg_rdata;
    logic       ext_trig = 1'b0;
    logic       conv_start;
    logic [1:0] conv_chan;
    logic       conv_done;
    logic [3:0] sh_sample;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    adc_seq_ctrl #(.SMP_CYCLES(SMP)) dut (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ext_trig   (ext_trig),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .conv_done  (conv_done),
        .sh_sample  (sh_sample)
    );

    // converter model: fixed latency, one-cycle done
    int cvt_cnt;
    always @(posedge clk) begin
        if (rst) begin
            cvt_cnt   <= 0;
            conv_done <= 1'b0;
        end else begin
            conv_done <= 1'b0;
            if (conv_start)
                cvt_cnt <= LAT;
            else if (cvt_cnt != 0) begin
                cvt_cnt <= cvt_cnt - 1;
                if (cvt_cnt == 1)
                    conv_done <= 1'b1;
            end
        end
    end

    // log of converted channels
    logic [1:0] chlog [64];
    logic [5:0] nlog;
    always @(posedge clk) begin
        if (rst)
            nlog <= '0;
        else if (conv_start) begin
            chlog[nlog] <= conv_chan;
            nlog        <= nlog + 1'b1;
        end
    end

    function automatic logic [9:0] cw(input logic wide, input logic [1:0] chs,
                                      input logic [2:0] trg, input logic gang,
                                      input logic auto_go, input logic dn,
                                      input logic smp);
        return {wide, chs, trg, gang, auto_go, dn, smp};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!reg_rdata[1] && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(reg_rdata[1] == 1'b1, tag, 32'(reg_rdata[1]), 1);
    endtask

    task automatic t_reset();
        chk(reg_rdata == '0, "R1 word", 32'(reg_rdata), 0);
        chk(sh_sample == '0, "R1 sh", 32'(sh_sample), 0);
        chk(conv_start == 1'b0, "R1 start", 32'(conv_start), 0);
    endtask

    task automatic t_manual();
        logic [5:0] base;
        wr(cw(0, 2'b00, 3'b000, 0, 0, 0, 1));
        chk(reg_rdata == cw(0, 2'b00, 3'b000, 0, 0, 0, 1), "R2 word",
            32'(reg_rdata), 32'(cw(0, 2'b00, 3'b000, 0, 0, 0, 1)));
        chk(sh_sample == 4'b0001, "R2 sh", 32'(sh_sample), 1);
        for (int k = 0; k < 5; k++) @(negedge clk);
        chk(reg_rdata[0] && !conv_start, "R3 holds tracking",
            32'(reg_rdata[0]), 1);
        base = nlog;
        wr(cw(0, 2'b00, 3'b000, 0, 0, 0, 0));
        chk(conv_start && conv_chan == 2'd0, "R3 start ch0",
            32'({conv_start, conv_chan}), 32'h4);
        chk(reg_rdata[0] == 1'b0, "R3 tracking off", 32'(reg_rdata[0]), 0);
        @(negedge clk);
        chk(conv_start == 1'b0, "R3 pulse width", 32'(conv_start), 0);
        wait_done("R6 single done");
        chk(nlog - base == 6'd1, "R5 one start", 32'(nlog - base), 1);
    endtask

    task automatic t_done_sw();
        wr(cw(0, 2'b00, 3'b000, 0, 0, 1, 0));
        chk(reg_rdata[1] == 1'b1, "R7 write1 keeps", 32'(reg_rdata[1]), 1);
        wr(cw(0, 2'b00, 3'b000, 0, 0, 0, 0));
        chk(reg_rdata[1] == 1'b0, "R7 write0 clears", 32'(reg_rdata[1]), 0);
        wr(cw(0, 2'b00, 3'b000, 0, 0, 1, 0));
        chk(reg_rdata[1] == 1'b0, "R7 write1 no set", 32'(reg_rdata[1]), 0);
    endtask

    task automatic t_seq4();
        logic [5:0] base;
        int n;
        wr(cw(0, 2'b10, 3'b000, 0, 0, 0, 1));
        chk(sh_sample == 4'b1111, "R2 sh four", 32'(sh_sample), 32'hf);
        base = nlog;
        wr(cw(0, 2'b10, 3'b000, 0, 0, 0, 0));
        chk(sh_sample == 4'b1110, "R8 seq ch0", 32'(sh_sample), 32'he);
        n = 0;
        while (!(conv_start && conv_chan == 2'd1) && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(sh_sample == 4'b1100, "R8 seq ch1", 32'(sh_sample), 32'hc);
        chk(reg_rdata[1] == 1'b0, "R6 no early done", 32'(reg_rdata[1]), 0);
        wr(cw(0, 2'b10, 3'b000, 0, 0, 0, 0));
        wait_done("R7 clear mid-seq done");
        chk(nlog - base == 6'd4, "R5 four starts", 32'(nlog - base), 4);
        for (int i = 0; i < 4; i++)
            chk(chlog[base + 6'(i)] == 2'(i), "R5 order",
                32'(chlog[base + 6'(i)]), 32'(i));
    endtask

    task automatic t_sim2();
        logic [5:0] base;
        wr(cw(0, 2'b01, 3'b000, 1, 0, 0, 1));
        chk(sh_sample == 4'b0011, "R2 sh two", 32'(sh_sample), 3);
        base = nlog;
        wr(cw(0, 2'b01, 3'b000, 1, 0, 0, 0));
        chk(sh_sample == 4'b0000, "R8 gang hold", 32'(sh_sample), 0);
        wait_done("R6 gang done");
        chk(nlog - base == 6'd2 && chlog[base] == 2'd0 &&
            chlog[base + 6'd1] == 2'd1, "R5 gang order",
            32'(nlog - base), 2);
    endtask

    task automatic t_wide();
        wr(cw(1, 2'b10, 3'b000, 1, 0, 0, 1));
        chk(reg_rdata == cw(1, 2'b10, 3'b000, 0, 0, 0, 1), "R9 gang reads0",
            32'(reg_rdata), 32'(cw(1, 2'b10, 3'b000, 0, 0, 0, 1)));
        wr(cw(1, 2'b10, 3'b000, 1, 0, 0, 0));
        chk(sh_sample == 4'b1110, "R9 acts sequential", 32'(sh_sample), 32'he);
        wait_done("R9 done");
    endtask

    task automatic t_ext();
        wr(cw(0, 2'b00, 3'b001, 0, 0, 0, 1));
        wr(cw(0, 2'b00, 3'b001, 0, 0, 0, 0));
        chk(reg_rdata[0] == 1'b1, "R4 sw end ignored", 32'(reg_rdata[0]), 1);
        for (int k = 0; k < 20; k++) @(negedge clk);
        chk(reg_rdata[0] && !conv_start, "R4 waits trig", 32'(reg_rdata[0]), 1);
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
        chk(conv_start && !reg_rdata[0], "R4 ext ends",
            32'({conv_start, reg_rdata[0]}), 2);
        wait_done("R4 ext done");
    endtask

    task automatic t_timer();
        bit ok = 1'b1;
        wr(cw(0, 2'b00, 3'b010, 0, 0, 0, 1));
        for (int k = 1; k < SMP; k++) begin
            @(negedge clk);
            if (!reg_rdata[0] || conv_start) ok = 1'b0;
        end
        chk(ok, "R4 timer early", 32'(ok), 1);
        @(negedge clk);
        chk(conv_start && !reg_rdata[0], "R4 timer expiry",
            32'({conv_start, reg_rdata[0]}), 2);
        wait_done("R4 timer done");
    endtask

    task automatic t_auto();
        wr(cw(0, 2'b00, 3'b010, 0, 1, 0, 0));
        chk(reg_rdata[0] == 1'b0, "R10 not yet", 32'(reg_rdata[0]), 0);
        @(negedge clk);
        chk(reg_rdata[0] == 1'b1, "R10 auto enter", 32'(reg_rdata[0]), 1);
        wait_done("R10 first done");
        chk(reg_rdata[0] == 1'b1, "R10 hw restart", 32'(reg_rdata[0]), 1);
        wr(cw(0, 2'b00, 3'b010, 0, 0, 0, 0));
        chk(reg_rdata[0] == 1'b1, "R4 sw end ignored tmr", 32'(reg_rdata[0]), 1);
        wait_done("R10 second done");
        chk(reg_rdata[0] == 1'b0, "R10 no restart", 32'(reg_rdata[0]), 0);
        for (int k = 0; k < 3; k++) @(negedge clk);
        chk(reg_rdata[0] == 1'b0, "R10 stays idle", 32'(reg_rdata[0]), 0);
    endtask

    task automatic t_collide();
        int n = 0;
        wr(cw(0, 2'b01, 3'b000, 0, 0, 0, 1));
        wr(cw(0, 2'b01, 3'b000, 0, 0, 0, 0));
        while (!(conv_done && conv_chan == 2'd1) && n < 100) begin
            @(negedge clk);
            n++;
        end
        reg_we    = 1'b1;
        reg_wdata = cw(0, 2'b01, 3'b000, 0, 0, 0, 0);
        @(negedge clk);
        reg_we    = 1'b0;
        chk(reg_rdata[1] == 1'b1, "R7 hw set wins", 32'(reg_rdata[1]), 1);
        chk(reg_rdata[0] == 1'b0, "R7 seq finished", 32'(reg_rdata[0]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_manual();
        t_done_sw();
        t_seq4();
        t_sim2();
        t_wide();
        t_ext();
        t_timer();
        t_auto();
        t_collide();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule